// File: doc/BRIEF.md
# Parallel EEPROM Page Writer with Completion Polling

This block is the host side of a byte-wide parallel EEPROM. On a start command it takes a page-aligned base address, a byte count of 1 to 64 and a polling mode. It then draws bytes from a ready/valid stream and issues them to the device as one page write, with the write strobes back to back. It stops when the count is reached or the stream runs dry. After that it stays quiet until the device's byte-load window has surely closed, and then polls the device through the data bus until the internal programming cycle ends.

Two completion tests are available. In data-polling mode the host rereads the last byte written and waits until bit 7 comes back equal to the written bit 7. In toggle mode the host rereads the device and waits until bit 6 stops changing between two reads. The block ends a transaction with a one-cycle `done` pulse, or with a one-cycle `err_tmo` pulse if the polling budget runs out. A malformed request gives an `err_req` pulse and no bus activity at all.

All bus timing is counted in clock cycles. The parameters set the address and data setup time before the strobe, the strobe width, the hold time after the strobe, the byte-load window and the polling timeout.

Top module: `eeprom_page_writer`

## Requirements
- R1: A start in idle whose base address has any of its low log2(PAGE_BYTES) bits set, or whose length is 0 or above PAGE_BYTES, gives `err_req` high for exactly the next cycle. Such a start drives no strobe, never raises `in_ready` and leaves `busy` low.
- R2: During a write strobe, `ee_ce_n` and `ee_we_n` are low and `ee_oe_n` is high. `ee_dq_oe` stays high, and `ee_addr` and `ee_dq_o` stay constant, from the falling edge of `ee_we_n` through the first cycle after its rising edge.
- R3: Bytes are accepted only when `in_ready` and `in_valid` are both high. Accepted byte k is written to address base+k, in acceptance order, so every write of a page shares the base's upper address bits. The block waits for the first byte indefinitely.
- R4: While the stream stays valid, each falling edge of `ee_we_n` in a page comes exactly SETUP_CYC+PULSE_CYC+HOLD_CYC+2 cycles after the previous one. This spacing must be shorter than WINDOW_CYC.
- R5: If `in_valid` is low when a further byte is due after at least one write, loading stops with fewer writes than the length. Polling then treats the last byte actually written as its reference.
- R6: In data-polling mode (`poll_mode`=0), every read uses the address of the last byte written. The transaction completes on the first read whose bit 7 equals bit 7 of that byte.
- R7: In toggle mode (`poll_mode`=1), the transaction completes on the first read whose bit 6 equals bit 6 of the read just before it.
- R8: During a read strobe, `ee_ce_n` and `ee_oe_n` are low and `ee_we_n` is high. `ee_dq_oe` is low throughout the strobe and in the cycle before `ee_oe_n` falls.
- R9: If completion is not seen within TIMEOUT_CYC polling cycles, the read that ends after the budget gives `err_tmo` for one cycle instead of `done`, and the block returns to idle.
- R10: `busy` is high from an accepted start until the result pulse. A start while busy has no effect, and each accepted request gives exactly one `done` or `err_tmo` pulse.
- R11: Out of reset, all three strobes are high, and `ee_dq_oe`, `in_ready`, `busy`, `done`, `err_req` and `err_tmo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a page write (sampled in idle) |
| base_addr | input | ADDR_W | Page-aligned start address |
| length | input | log2(PAGE_BYTES)+1 | Number of bytes, 1..PAGE_BYTES |
| poll_mode | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle polling |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes the stream byte this cycle |
| ee_ce_n | output | 1 | Device chip enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_we_n | output | 1 | Device write enable, active low |
| ee_addr | output | ADDR_W | Device address bus |
| ee_dq_o | output | 8 | Data bus value driven by the host |
| ee_dq_oe | output | 1 | Host drives the data bus when high |
| ee_dq_i | input | 8 | Data bus value seen by the host |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: programming complete |
| err_req | output | 1 | One-cycle pulse: request rejected |
| err_tmo | output | 1 | One-cycle pulse: polling timed out |

## Verification
A wrong sequencer phase or counter shows up at once on the strobe pins. The first malformed strobe has the wrong overlap of the three enables, lets the bus move under an active strobe, or puts a falling-edge spacing off by a cycle, and it does so within one byte slot. A wrong byte index or page register shows up as a wrong address or data value when the scoreboard pops that write. A broken completion evaluator or poll state costs a wrong number of status reads before `done`, which is visible as soon as the transaction ends. Timer faults make `err_tmo` appear where `done` is due, or the reverse.

// File: rtl/pgw_pkg.sv
// Shared types for the EEPROM page writer.
// Assumes: nothing beyond SystemVerilog enums.
package pgw_pkg;

    // Controller states of the top-level sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_WINDOW,
        ST_POLL_GO,
        ST_POLL_WAIT
    } pgw_state_e;

    // Phases of one device bus cycle.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } pgw_phase_e;

    localparam logic POLL_DATA   = 1'b0;
    localparam logic POLL_TOGGLE = 1'b1;

endpackage

// File: rtl/pgw_req_check.sv
// Request validator: a request is legal when the base address sits on a
// page boundary and the length is between 1 and PAGE_BYTES.
// Assumes: PAGE_BYTES is a power of two.
module pgw_req_check #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [$clog2(PAGE_BYTES):0]   length,
    output logic                          ok
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int LEN_W = OFF_W + 1;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(PAGE_BYTES);

    logic aligned;
    logic len_ok;

    // Page alignment and length range tests.
    always_comb begin
        aligned = (base_addr[OFF_W-1:0] == '0);
        len_ok  = (length != '0) && (length <= MAX_LEN);
        ok      = aligned && len_ok;
    end
endmodule

// File: rtl/pgw_timer.sv
// Saturating cycle counter: counts enabled cycles after a clear and
// reports when LIMIT has been reached.
// Assumes: LIMIT >= 1; clear has priority over enable.
module pgw_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Count enabled cycles up to the limit, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != LIM)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign expired = (cnt == LIM);

    // Once reached, the limit stays reached until cleared (R9).
    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired);
endmodule

// File: rtl/pgw_poll_eval.sv
// Completion evaluator for status reads. In data mode a read is final when
// its bit 7 equals the reference bit 7 of the last written byte. In toggle
// mode a read is final when its bit 6 equals bit 6 of the previous read.
// Assumes: st_in is stable while complete is used; clr precedes each poll.
module pgw_poll_eval
    import pgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sample,
    input  logic       mode,
    input  logic [1:0] st_in,     // [1] = bus bit 7, [0] = bus bit 6
    input  logic       ref_bit7,
    output logic       complete
);
    logic have_prev;
    logic prev_b6;

    // Remember bit 6 of the latest status read for the toggle test.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_b6   <= 1'b0;
        end else if (clr) begin
            have_prev <= 1'b0;
        end else if (sample) begin
            have_prev <= 1'b1;
            prev_b6   <= st_in[0];
        end
    end

    // Decide whether the current read shows the end of programming.
    always_comb begin
        if (mode == POLL_DATA) begin
            complete = (st_in[1] == ref_bit7);
        end else begin
            complete = have_prev && (st_in[0] == prev_b6);
        end
    end

    // A toggle completion needs a read before it (R7).
    p_two_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && (mode == POLL_TOGGLE) && complete) |-> have_prev);
endmodule

// File: rtl/pgw_bus_seq.sv
// Device bus cycle generator. On go it latches the address, the data and
// the direction, then runs: setup (bus stable, strobes high), strobe
// (CE with WE or OE low), hold (strobes high, bus kept). It ends with a
// one-cycle cyc_done. Reads capture bus bits 7 and 6 in the last strobe
// cycle. During read setup the host releases the bus.
// Assumes: go only while idle; every phase length >= 1.
module pgw_bus_seq
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 10,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        wdata,
    input  logic [1:0]        st_bus,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        dq_o,
    output logic              dq_oe,
    output logic              cyc_done,
    output logic [1:0]        st_q
);
    localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] SET_L = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PUL_L = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HLD_L = CNT_W'(HOLD_CYC - 1);

    pgw_phase_e         phase;
    logic [CNT_W-1:0]   cnt;
    logic               rd_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [7:0]         data_q;
    logic               done_q;

    // Phase sequencing, operand capture and status sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            st_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase  <= PH_SETUP;
                        cnt    <= SET_L;
                        rd_q   <= rd;
                        addr_q <= addr_in;
                        data_q <= wdata;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= PUL_L;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= HLD_L;
                        if (rd_q) begin
                            st_q <= st_bus;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin levels follow the phase register.
    always_comb begin
        ce_n     = (phase != PH_STROBE);
        we_n     = !((phase == PH_STROBE) && !rd_q);
        oe_n     = !((phase == PH_STROBE) && rd_q);
        dq_oe    = (phase != PH_IDLE) && !rd_q;
        addr_o   = addr_q;
        dq_o     = data_q;
        cyc_done = done_q;
    end

    // Address and data do not move across a write strobe or its first hold cycle (R2).
    p_write_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || $past(!we_n)) |-> ($stable(addr_o) && $stable(dq_o) && dq_oe));

    // The host has released the bus before OE falls and while OE is low (R8).
    p_release_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> ($past(!dq_oe) && !dq_oe));

    // Read and write strobes never overlap (R8).
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !ce_n));
endmodule

// File: rtl/eeprom_page_writer.sv
// Host-side page writer for a byte-wide parallel EEPROM. It validates a
// request, streams up to PAGE_BYTES bytes into one page with back-to-back
// write cycles, waits out the byte-load window, and then polls for the end
// of programming by bit-7 data polling or bit-6 toggle polling. It ends with
// a done or timeout pulse.
// Assumes: WINDOW_CYC exceeds one write slot; the stream either supplies a
// byte when asked or is treated as finished once a byte has been written.
module eeprom_page_writer
    import pgw_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_BYTES  = 64,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 10,
    parameter int HOLD_CYC    = 2,
    parameter int WINDOW_CYC  = 15000,
    parameter int TIMEOUT_CYC = 1000000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ADDR_W-1:0]           base_addr,
    input  logic [$clog2(PAGE_BYTES):0] length,
    input  logic                        poll_mode,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    output logic                        in_ready,
    output logic                        ee_ce_n,
    output logic                        ee_oe_n,
    output logic                        ee_we_n,
    output logic [ADDR_W-1:0]           ee_addr,
    output logic [7:0]                  ee_dq_o,
    output logic                        ee_dq_oe,
    input  logic [7:0]                  ee_dq_i,
    output logic                        busy,
    output logic                        done,
    output logic                        err_req,
    output logic                        err_tmo
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int LEN_W = OFF_W + 1;
    localparam int PG_W  = ADDR_W - OFF_W;
    localparam int SLOT  = SETUP_CYC + PULSE_CYC + HOLD_CYC + 2;

    pgw_state_e          state;
    logic [PG_W-1:0]     base_pg;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    idx;
    logic                mode_q;
    logic [ADDR_W-1:0]   last_addr;
    logic                last_b7;
    logic                done_q;
    logic                err_req_q;
    logic                err_tmo_q;

    logic [ADDR_W-1:0]   wr_addr;
    logic                req_ok;
    logic                seq_go;
    logic                seq_rd;
    logic [ADDR_W-1:0]   seq_addr;
    logic                seq_done;
    logic [1:0]          seq_st;
    logic                win_exp;
    logic                tmo_exp;
    logic                poll_ok;
    logic                polling;

    // The byte-load window must outlast one write slot.
    initial begin
        assert (WINDOW_CYC > SLOT);
    end

    pgw_req_check #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_req (
        .base_addr (base_addr),
        .length    (length),
        .ok        (req_ok)
    );

    // Address of the next byte in the page and bus-cycle requests.
    always_comb begin
        wr_addr  = {base_pg, idx[OFF_W-1:0]};
        polling  = (state == ST_POLL_GO) || (state == ST_POLL_WAIT);
        seq_go   = ((state == ST_FETCH) && in_valid) || (state == ST_POLL_GO);
        seq_rd   = (state == ST_POLL_GO);
        seq_addr = (state == ST_FETCH) ? wr_addr : last_addr;
    end

    pgw_bus_seq #(
        .ADDR_W    (ADDR_W),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (seq_go),
        .rd       (seq_rd),
        .addr_in  (seq_addr),
        .wdata    (in_data),
        .st_bus   (ee_dq_i[7:6]),
        .ce_n     (ee_ce_n),
        .oe_n     (ee_oe_n),
        .we_n     (ee_we_n),
        .addr_o   (ee_addr),
        .dq_o     (ee_dq_o),
        .dq_oe    (ee_dq_oe),
        .cyc_done (seq_done),
        .st_q     (seq_st)
    );

    pgw_timer #(.LIMIT(WINDOW_CYC)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != ST_WINDOW),
        .en      (1'b1),
        .expired (win_exp)
    );

    pgw_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_WINDOW),
        .en      (polling),
        .expired (tmo_exp)
    );

    pgw_poll_eval u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == ST_WINDOW),
        .sample   ((state == ST_POLL_WAIT) && seq_done),
        .mode     (mode_q),
        .st_in    (seq_st),
        .ref_bit7 (last_b7),
        .complete (poll_ok)
    );

    // Transaction sequencing: request, byte loading, window, polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_pg   <= '0;
            len_q     <= '0;
            idx       <= '0;
            mode_q    <= POLL_DATA;
            last_addr <= '0;
            last_b7   <= 1'b0;
            done_q    <= 1'b0;
            err_req_q <= 1'b0;
            err_tmo_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            err_req_q <= 1'b0;
            err_tmo_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (req_ok) begin
                            state   <= ST_FETCH;
                            base_pg <= base_addr[ADDR_W-1:OFF_W];
                            len_q   <= length;
                            mode_q  <= poll_mode;
                            idx     <= '0;
                        end else begin
                            err_req_q <= 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (in_valid) begin
                        idx       <= idx + LEN_W'(1);
                        last_addr <= wr_addr;
                        last_b7   <= in_data[7];
                        state     <= ST_WRITE;
                    end else if (idx != '0) begin
                        state <= ST_WINDOW;
                    end
                end
                ST_WRITE: begin
                    if (seq_done) begin
                        state <= (idx == len_q) ? ST_WINDOW : ST_FETCH;
                    end
                end
                ST_WINDOW: begin
                    if (win_exp) begin
                        state <= ST_POLL_GO;
                    end
                end
                ST_POLL_GO: begin
                    state <= ST_POLL_WAIT;
                end
                ST_POLL_WAIT: begin
                    if (seq_done) begin
                        if (poll_ok) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (tmo_exp) begin
                            err_tmo_q <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            state <= ST_POLL_GO;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake and result outputs.
    always_comb begin
        in_ready = (state == ST_FETCH);
        busy     = (state != ST_IDLE);
        done     = done_q;
        err_req  = err_req_q;
        err_tmo  = err_tmo_q;
    end

    // A malformed request is refused without leaving idle (R1).
    p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && start && !req_ok) |=> ((state == ST_IDLE) && err_req));

    // Every write of a transaction stays in the latched page (R3).
    p_same_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_we_n |-> (ee_addr[ADDR_W-1:OFF_W] == base_pg));

    // A timeout is only reported once the polling budget is spent (R9).
    p_tmo_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> $past(tmo_exp));

    // Result pulses last one cycle and never coincide (R10).
    p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_tmo) |=> !(done || err_tmo));

    // A start during a transaction is not treated as a request (R10).
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && start) |=> !err_req);
endmodule

// File: tb/eeprom_page_writer_bench.sv
// Scoreboard bench: the driver task queues the expected page writes, a
// negedge monitor pops and compares them at each write strobe, and a small
// device model answers status reads.
module eeprom_page_writer_bench;
    localparam int AW   = 15;
    localparam int PB   = 64;
    localparam int SU   = 2;
    localparam int PW   = 3;
    localparam int HD   = 1;
    localparam int WIN  = 20;
    localparam int TMO  = 400;
    localparam int SLOT = SU + PW + HD + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [6:0]    length = '0;
    logic          poll_mode = 1'b0;
    logic          in_valid;
    logic [7:0]    in_data;
    logic          in_ready;
    logic          ee_ce_n, ee_oe_n, ee_we_n;
    logic [AW-1:0] ee_addr;
    logic [7:0]    ee_dq_o;
    logic          ee_dq_oe;
    logic [7:0]    ee_dq_i;
    logic          busy, done, err_req, err_tmo;

    always #5 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(AW), .PAGE_BYTES(PB), .SETUP_CYC(SU), .PULSE_CYC(PW),
        .HOLD_CYC(HD), .WINDOW_CYC(WIN), .TIMEOUT_CYC(TMO)
    ) u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .length(length), .poll_mode(poll_mode), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .ee_ce_n(ee_ce_n),
        .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_addr(ee_addr),
        .ee_dq_o(ee_dq_o), .ee_dq_oe(ee_dq_oe), .ee_dq_i(ee_dq_i),
        .busy(busy), .done(done), .err_req(err_req), .err_tmo(err_tmo)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- stream source and device model ----------------
    logic [7:0] stream [0:63];
    int         ptr = 0;
    int         avail = 0;
    bit         clr = 1'b0;
    logic [7:0] model_last = '0;
    int         model_busy = 0;
    int         model_reads = 0;
    logic       tog = 1'b0;
    logic       prev_oe_m = 1'b1;
    logic       model_busy_now;

    assign in_valid = (ptr < avail);
    assign in_data  = stream[ptr[5:0]];
    assign model_busy_now = (model_reads < model_busy);

    // Status answer: complemented bit 7 and a toggling bit 6 while busy.
    always_comb begin
        ee_dq_i = model_last;
        if (model_busy_now) ee_dq_i[7] = ~model_last[7];
        ee_dq_i[6] = poll_mode ? tog : (model_busy_now ? model_last[6] : model_last[6]);
    end

    // Stream pointer and model read counter advance at clock edges.
    always @(posedge clk) begin
        prev_oe_m <= ee_oe_n;
        if (clr) begin
            ptr <= 0;
            model_reads <= 0;
            tog <= 1'b0;
        end else begin
            if (in_ready && in_valid) ptr <= ptr + 1;
            if (!prev_oe_m && ee_oe_n) begin
                if (model_busy_now) tog <= ~tog;
                model_reads <= model_reads + 1;
            end
        end
    end

    // ---------------- monitor / scoreboard ----------------
    logic [AW-1:0] exp_addr [$];
    logic [7:0]    exp_data [$];
    logic [AW-1:0] rd_addr_exp = '0;
    int  cyc = 0;
    int  writes_seen = 0, reads_seen = 0, ready_seen = 0;
    int  last_fall = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_dq_oe = 1'b0;
    logic [AW-1:0] cap_addr = '0;
    logic [7:0]    cap_data = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (clr) begin
            writes_seen = 0; reads_seen = 0; ready_seen = 0;
        end else if (rst_n) begin
            if (in_ready) ready_seen++;
            if (!ee_we_n) begin
                chk(!ee_ce_n && ee_oe_n && ee_dq_oe, "R2", "strobe levels ce/oe/dq_oe",
                    {ee_ce_n, ee_oe_n, ee_dq_oe}, 3'b011);
                if (prev_we) begin
                    if (writes_seen > 0)
                        chk(cyc - last_fall == SLOT, "R4", "write strobe spacing",
                            cyc - last_fall, SLOT);
                    last_fall = cyc;
                    cap_addr = ee_addr;
                    cap_data = ee_dq_o;
                end else begin
                    chk(ee_addr == cap_addr && ee_dq_o == cap_data, "R2",
                        "bus moved during strobe", int'(ee_addr), int'(cap_addr));
                end
            end else if (!prev_we) begin
                chk(ee_dq_oe && ee_addr == cap_addr && ee_dq_o == cap_data, "R2",
                    "hold after strobe", int'(ee_dq_oe), 1);
                writes_seen++;
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write", int'(cap_addr), -1);
                end else begin
                    logic [AW-1:0] ea;
                    logic [7:0]    ed;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    chk(cap_addr == ea, "R3", "write address", int'(cap_addr), int'(ea));
                    chk(cap_data == ed, "R3", "write data", int'(cap_data), int'(ed));
                end
            end
            if (!ee_oe_n) begin
                chk(ee_we_n && !ee_ce_n && !ee_dq_oe, "R8", "read levels we/ce/dq_oe",
                    {ee_we_n, ee_ce_n, ee_dq_oe}, 3'b100);
                chk(ee_addr == rd_addr_exp, "R6", "status read address",
                    int'(ee_addr), int'(rd_addr_exp));
                if (prev_oe) begin
                    chk(!prev_dq_oe, "R8", "bus released before OE", int'(prev_dq_oe), 0);
                    reads_seen++;
                end
            end
        end
        prev_we = ee_we_n;
        prev_oe = ee_oe_n;
        prev_dq_oe = ee_dq_oe;
    end

    // ---------------- driver ----------------
    task automatic clear_run();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run_page(input logic [AW-1:0] base, input int len, input int avl,
                            input bit mode, input int breads, input bit exp_tmo,
                            input bit poke, input string req);
        int n;
        bit saw_done, saw_tmo;
        int exp_reads;
        n = (len < avl) ? len : avl;
        exp_addr.delete();
        exp_data.delete();
        for (int k = 0; k < 64; k++) stream[k] = 8'((k * 37 + 5) ^ int'(base[7:0]));
        for (int k = 0; k < n; k++) begin
            exp_addr.push_back(base + AW'(k));
            exp_data.push_back(stream[k]);
        end
        model_last  = stream[n-1];
        model_busy  = breads;
        rd_addr_exp = base + AW'(n - 1);
        avail = 0;
        clear_run();
        avail = avl;
        poll_mode = mode;
        base_addr = base;
        length = 7'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10", "busy after accepted start", int'(busy), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(busy, "R10", "busy during load", int'(busy), 1);
            base_addr = 15'h0100;
            length = 7'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        saw_done = 1'b0;
        saw_tmo = 1'b0;
        for (int i = 0; i < 20000 && !saw_done && !saw_tmo; i++) begin
            @(negedge clk);
            if (done) saw_done = 1'b1;
            if (err_tmo) saw_tmo = 1'b1;
        end
        chk(saw_tmo == exp_tmo, "R9", "timeout result", int'(saw_tmo), int'(exp_tmo));
        chk(saw_done == !exp_tmo, "R10", "done result", int'(saw_done), int'(!exp_tmo));
        chk(writes_seen == n, "R5", "number of writes", writes_seen, n);
        chk(exp_addr.size() == 0, "R3", "writes left in queue", exp_addr.size(), 0);
        if (!exp_tmo) begin
            exp_reads = mode ? breads + 2 : breads + 1;
            chk(reads_seen == exp_reads, mode ? "R7" : "R6", "status reads to completion",
                reads_seen, exp_reads);
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err_tmo, req, "idle after result",
            {busy, done, err_tmo}, 0);
    endtask

    task automatic bad_req(input logic [AW-1:0] base, input int len);
        avail = 0;
        clear_run();
        base_addr = base;
        length = 7'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err_req, "R1", "err_req after bad request", int'(err_req), 1);
        @(negedge clk);
        chk(!err_req && !busy, "R1", "err_req one cycle, not busy", {err_req, busy}, 0);
        repeat (10) @(negedge clk);
        chk(writes_seen == 0 && reads_seen == 0 && ready_seen == 0, "R1",
            "no bus activity", writes_seen + reads_seen + ready_seen, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ee_ce_n && ee_oe_n && ee_we_n, "R11", "strobes idle",
            {ee_ce_n, ee_oe_n, ee_we_n}, 3'b111);
        chk(!ee_dq_oe && !in_ready && !busy, "R11", "bus and handshake idle",
            {ee_dq_oe, in_ready, busy}, 0);
        chk(!done && !err_req && !err_tmo, "R11", "results idle",
            {done, err_req, err_tmo}, 0);

        bad_req(15'h0041, 4);   // R1 misaligned
        bad_req(15'h0000, 0);   // R1 zero length
        bad_req(15'h0040, 65);  // R1 over length

        run_page(15'h7FC0, 64, 64, 1'b0, 3, 1'b0, 1'b0, "R4");  // full page, data poll
        run_page(15'h0000, 1, 64, 1'b0, 0, 1'b0, 1'b0, "R6");   // single byte
        run_page(15'h1240, 5, 64, 1'b1, 2, 1'b0, 1'b0, "R7");   // toggle mode
        run_page(15'h0080, 2, 64, 1'b1, 0, 1'b0, 1'b0, "R7");   // toggle, ready at once
        run_page(15'h0200, 10, 4, 1'b0, 1, 1'b0, 1'b0, "R5");   // stream runs dry
        run_page(15'h0400, 3, 64, 1'b0, 100000, 1'b1, 1'b0, "R9"); // never completes
        run_page(15'h0800, 8, 64, 1'b1, 1, 1'b0, 1'b1, "R10");  // start while busy

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule